// File: doc/BRIEF.md
# Modulo-11 / Windowed Clock Divider with Registered State Decodes

This block divides its clock by running a 4-bit synchronous counter through a shortened loop instead of the full 16 states. A 2-bit select picks one of three loops. In reload mode the counter jumps back to 5 after 15. In clear mode it returns to 0 after 10. In window mode it runs from 3 to 12 and then starts again at 3. The select is captured only while the synchronous reset is held, so a running loop never changes shape partway through.

A terminal-count pulse marks the last state of each loop. The block can use it as the divided clock enable, or it can feed a following stage. A bank of sixteen one-hot state decodes comes from a register rather than from gates on the counter bits. The decodes are therefore free of glitches, and each one lags the count it names by one clock.

Control is a small decision machine. It has three actions: STEP (count up), LOAD (take the first value of the sequence), and CLEAR (go to zero). Reset always selects LOAD with the first value of the newly selected mode. In the final state, clear mode selects CLEAR and the other modes select LOAD. Every other cycle is STEP.

Top module: `mod_divider_top`

## Requirements
- R1: While `rst` is high at a clock edge, the counter takes the first value of the sequence selected by `mode_sel`: 5 for 00 or 11, 0 for 01, 3 for 10. In the same edge `dec` becomes all zero. `tc` is low after reset.
- R2: Reload mode (`mode_sel` 00 or 11) counts 5,6,...,15 and then 5 again. This is 11 states, so the clock is divided by 11.
- R3: Clear mode (`mode_sel` 01) counts 0,1,...,10 and then 0 again (modulo 11). The end state is found from count bits 3 and 1 alone.
- R4: Window mode (`mode_sel` 10) counts 3,4,...,12 and then 3 again. The count never leaves that range.
- R5: `tc` is high exactly while the count holds the last value of the active sequence (15, 10 or 12). It therefore pulses once for one clock per loop.
- R6: `dec` is one-hot. Bit k is set when the count was k one clock earlier, except in the first clock after reset, when `dec` is zero.
- R7: A change on `mode_sel` while `rst` is low has no effect on the count, on `tc` or on `dec`. It takes effect only at the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; also captures `mode_sel` |
| mode_sel | input | 2 | Sequence select: 00/11 reload, 01 clear, 10 window |
| count | output | 4 | Present counter value |
| tc | output | 1 | Terminal-count pulse, high in the last state of the loop |
| dec | output | 16 | Registered one-hot decode of the previous count |

## Verification
The assertions assume that `rst` is held for at least one edge before the count is judged. They also assume that `clk` runs cleanly. They place no limit on `mode_sel` after reset, because the captured mode must ignore it. The stimulus resets the block in all four select codes. It then runs each loop for three full periods and compares every cycle against an arithmetic model. In the middle of each run it flips `mode_sel` to another code, so the hold-until-reset rule is exercised under the same checks.

// File: rtl/div_pkg.sv
package div_pkg;
    typedef enum logic [1:0] {
        SEQ_RELOAD = 2'd0,
        SEQ_CLEAR  = 2'd1,
        SEQ_WINDOW = 2'd2
    } seq_mode_t;

    typedef enum logic [1:0] {
        ACT_STEP  = 2'd0,
        ACT_LOAD  = 2'd1,
        ACT_CLEAR = 2'd2
    } ctl_act_t;

    function automatic seq_mode_t sel_to_mode(input logic [1:0] sel);
        seq_mode_t m;
        unique case (sel)
            2'b01:   m = SEQ_CLEAR;
            2'b10:   m = SEQ_WINDOW;
            default: m = SEQ_RELOAD;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/div_count.sv
module div_count #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         ld,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    // Priority: clear over load over count, all on the rising edge.
    always_ff @(posedge clk) begin
        if (clr)
            q <= '0;
        else if (ld)
            q <= din;
        else if (en)
            q <= q + 1'b1;
    end
endmodule

// File: rtl/div_decode.sv
module div_decode #(
    parameter int W = 4,
    localparam int N = 1 << W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] count,
    output logic [N-1:0] dec
);
    always_ff @(posedge clk) begin
        if (rst)
            dec <= '0;
        else
            dec <= {{(N-1){1'b0}}, 1'b1} << count;
    end

    p_dec_onehot_r6: assert property (@(posedge clk) $onehot0(dec));

    p_dec_lag_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> dec == ({{(N-1){1'b0}}, 1'b1} << $past(count)));
endmodule

// File: rtl/div_ctrl.sv
module div_ctrl
    import div_pkg::*;
#(
    parameter int W            = 4,
    parameter int RELOAD_START = 5,
    parameter int CLEAR_END    = 10,
    parameter int WINDOW_START = 3,
    parameter int WINDOW_END   = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   mode_sel,
    input  logic [W-1:0] count,
    output ctl_act_t     act,
    output logic [W-1:0] load_val,
    output logic         tc
);
    localparam logic [W-1:0] TOP_VAL = {W{1'b1}};
    localparam logic [W-1:0] RLD_V   = W'(RELOAD_START);
    localparam logic [W-1:0] CLR_E   = W'(CLEAR_END);
    localparam logic [W-1:0] WIN_S   = W'(WINDOW_START);
    localparam logic [W-1:0] WIN_E   = W'(WINDOW_END);

    seq_mode_t mode_q;
    seq_mode_t mode_in;
    logic      clear_hit;

    assign mode_in = sel_to_mode(mode_sel);

    // Mode register: captured only under reset.
    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= mode_in;
    end

    // End-of-clear-loop detection; the sparse form relies on 11, 14, 15 never occurring.
    generate
        if (W == 4 && CLEAR_END == 10) begin : g_sparse_end
            assign clear_hit = count[3] & count[1];
        end else begin : g_full_end
            assign clear_hit = (count == CLR_E);
        end
    endgenerate

    always_comb begin
        unique case (mode_q)
            SEQ_RELOAD: tc = (count == TOP_VAL);
            SEQ_CLEAR:  tc = clear_hit;
            SEQ_WINDOW: tc = (count == WIN_E);
            default:    tc = 1'b0;
        endcase
    end

    function automatic logic [W-1:0] first_of(input seq_mode_t m);
        logic [W-1:0] v;
        unique case (m)
            SEQ_CLEAR:  v = '0;
            SEQ_WINDOW: v = WIN_S;
            default:    v = RLD_V;
        endcase
        return v;
    endfunction

    // Action decision: reset -> LOAD; final state -> CLEAR or LOAD; otherwise STEP.
    always_comb begin
        if (rst) begin
            act      = ACT_LOAD;
            load_val = first_of(mode_in);
        end else if (tc) begin
            act      = (mode_q == SEQ_CLEAR) ? ACT_CLEAR : ACT_LOAD;
            load_val = first_of(mode_q);
        end else begin
            act      = ACT_STEP;
            load_val = first_of(mode_q);
        end
    end

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        !tc |=> count == $past(count) + 1'b1);

    p_clear_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (tc && mode_q == SEQ_CLEAR) |=> count == '0);

    p_window_range_r4: assert property (@(posedge clk) disable iff (rst)
        (mode_q == SEQ_WINDOW) |-> (count >= WIN_S && count <= WIN_E));

    p_tc_single_r5: assert property (@(posedge clk) disable iff (rst)
        tc |=> !tc);

    p_mode_hold_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(mode_q));
endmodule

// File: rtl/mod_divider_top.sv
module mod_divider_top
    import div_pkg::*;
#(
    parameter int W            = 4,
    parameter int RELOAD_START = 5,
    parameter int CLEAR_END    = 10,
    parameter int WINDOW_START = 3,
    parameter int WINDOW_END   = 12,
    localparam int N           = 1 << W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   mode_sel,
    output logic [W-1:0] count,
    output logic         tc,
    output logic [N-1:0] dec
);
    ctl_act_t     act;
    logic [W-1:0] load_val;
    logic         cnt_clr;
    logic         cnt_ld;
    logic         cnt_en;

    div_ctrl #(
        .W(W), .RELOAD_START(RELOAD_START), .CLEAR_END(CLEAR_END),
        .WINDOW_START(WINDOW_START), .WINDOW_END(WINDOW_END)
    ) u_ctrl (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .count(count),
        .act(act), .load_val(load_val), .tc(tc)
    );

    always_comb begin
        cnt_clr = 1'b0;
        cnt_ld  = 1'b0;
        cnt_en  = 1'b0;
        unique case (act)
            ACT_CLEAR: cnt_clr = 1'b1;
            ACT_LOAD:  cnt_ld  = 1'b1;
            ACT_STEP:  cnt_en  = 1'b1;
            default:   cnt_en  = 1'b0;
        endcase
    end

    div_count #(.W(W)) u_count (
        .clk(clk), .clr(cnt_clr), .ld(cnt_ld), .en(cnt_en),
        .din(load_val), .q(count)
    );

    div_decode #(.W(W)) u_decode (
        .clk(clk), .rst(rst), .count(count), .dec(dec)
    );
endmodule

// File: tb/tb_mod_divider_top.sv
`timescale 1ns/1ps
module tb_mod_divider_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode_sel = 2'b00;
    logic [3:0]  count;
    logic        tc;
    logic [15:0] dec;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    mod_divider_top dut (
        .clk(clk), .rst(rst), .mode_sel(mode_sel),
        .count(count), .tc(tc), .dec(dec)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_mode(input logic [1:0] sel);
        int first, last, period, exp_c, prev_c, pulses;
        string seq_tag;
        logic [15:0] exp_dec;
        bit swapped;
        first  = (sel == 2'b01) ? 0  : (sel == 2'b10) ? 3  : 5;
        last   = (sel == 2'b01) ? 10 : (sel == 2'b10) ? 12 : 15;
        seq_tag = (sel == 2'b01) ? "R3" : (sel == 2'b10) ? "R4" : "R2";
        period = last - first + 1;
        @(negedge clk);
        rst = 1'b1;
        mode_sel = sel;
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        chk(count == 4'(first), "R1 count", count, first);
        chk(dec == 16'd0, "R1 dec", dec, 0);
        chk(tc == 1'b0, "R1 tc", tc, 0);
        rst = 1'b0;
        exp_c = first;
        pulses = 0;
        swapped = 1'b0;
        for (int i = 0; i < 3 * period; i++) begin
            @(negedge clk);
            prev_c = exp_c;
            exp_c = (prev_c == last) ? first : prev_c + 1;
            exp_dec = 16'd1 << prev_c;
            // after the swap, the sequence must be unchanged (R7)
            chk(count == 4'(exp_c), swapped ? "R7 count" : seq_tag, count, exp_c);
            chk(dec == exp_dec, swapped ? "R7 dec" : "R6 dec", dec, exp_dec);
            chk(tc == (exp_c == last), "R5 tc", tc, (exp_c == last));
            if (tc) pulses++;
            if (i == period + 2) begin
                mode_sel = sel ^ 2'b11;
                swapped = 1'b1;
            end
        end
        chk(pulses == 3, "R5 pulses", pulses, 3);
    endtask

    initial begin
        run_mode(2'b00);
        run_mode(2'b01);
        run_mode(2'b10);
        run_mode(2'b11);
        // R7: a new code takes effect at the next reset
        run_mode(2'b01);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule